// File: doc/BRIEF.md
# Operand Address Exception Checker

This block screens every fixed-point operand access just before it executes. It decides whether the access must raise an address-error interrupt. Four independent tests run in parallel on the access:

- **Register pair:** a 64-bit operand held in a register pair must name an even register.
- **Alignment:** the operand must sit on a boundary that matches its size.
- **Range:** the whole operand must lie inside installed main memory.
- **Protection:** when protection is switched on, the program's key must fit the storage key of the target location.

The results are merged into one interrupt request. It comes with a cause code and an action code. The action code tells the sequencer either to suppress the instruction, leaving the condition code, registers and memory untouched, or to terminate it at the faulting point.

The checker is issued one access per cycle with a valid strobe. The request, cause and action are registered, so they appear one cycle after the access is presented. The screened operand is treated as the result location when keys are compared.

Top module: `opnd_addr_screen`

## Requirements
- R1: For size code 0 (halfword, 2 bytes), an address with bit 0 set reports cause 2 (alignment) with action 1 (suppress). Size code 3 (byte) is never misaligned.
- R2: For size code 1 (fullword, 4 bytes), an address whose two low bits are not both zero reports cause 2 with action 1.
- R3: For size code 2 (doubleword, 8 bytes), an address whose three low bits are not all zero reports cause 2 with action 1.
- R4: A register-pair operand (pair_op high) that names an odd register reports cause 1 (register pair) with action 1.
- R5: An operand whose last byte (address + size − 1) is at or above the installed memory size in bytes reports cause 3 (range) with action 2 (terminate).
- R6: With protection enabled, a protection key that does not fit the storage key reports cause 4 (protection). The action is 1 (suppress), or 2 (terminate) when is_stm marks a store-multiple.
- R7: With prot_en low, a key mismatch has no effect: the cause is never 4.
- R8: A protection key of zero matches every storage key and never causes a protection error.
- R9: When several tests fail together, the reported cause follows the priority register pair, then alignment, then range, then protection.
- R10: err_valid follows chk_valid one cycle later. When it reports no error, err_req is 0, the cause is 0 and the action is 0. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | An access is presented this cycle |
| eff_addr | input | ADDR_W | Operand effective byte address |
| opnd_size | input | 2 | 0 halfword, 1 fullword, 2 doubleword, 3 byte |
| pair_op | input | 1 | Operand lives in an even/odd register pair |
| reg_num | input | REG_W | Register number named by the instruction |
| mem_bytes | input | ADDR_W+1 | Installed main memory size in bytes |
| stor_key | input | KEY_W | Storage key of the target location |
| prot_key | input | KEY_W | Protection key of the running program |
| prot_en | input | 1 | Memory protection feature enabled |
| is_stm | input | 1 | Instruction is a store-multiple |
| err_valid | output | 1 | Registered copy of chk_valid |
| err_req | output | 1 | Address-error interrupt request |
| err_cause | output | 3 | 0 none, 1 register pair, 2 alignment, 3 range, 4 protection |
| err_action | output | 2 | 0 none, 1 suppress, 2 terminate |

## Verification
The bench targets the edges of each test:
- An operand whose first byte fits but whose last byte lands exactly on the memory size. A design that compared only the start address would let this access through without a range fault.
- Addresses misaligned by one bit only, for each size. A wrong mask would flag good doublewords or pass bad fullwords.
- Accesses that fail several tests at once. These expose a priority chain in the wrong order, which would report protection or range where the register pair should win.
- Key zero, protection disabled, and store-multiple against ordinary stores. These catch a missing master-key path, a protection check that ignores its enable, and a terminate action applied to the wrong opcode.

// File: rtl/opnd_screen_pkg.sv
package opnd_screen_pkg;

    typedef enum logic [1:0] {
        SZ_HALF   = 2'd0,
        SZ_FULL   = 2'd1,
        SZ_DOUBLE = 2'd2,
        SZ_BYTE   = 2'd3
    } opnd_size_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_REGPAIR = 3'd1,
        CAUSE_ALIGN   = 3'd2,
        CAUSE_RANGE   = 3'd3,
        CAUSE_PROTECT = 3'd4
    } err_cause_e;

    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,
        ACT_SUPPRESS  = 2'd1,
        ACT_TERMINATE = 2'd2
    } err_action_e;

    typedef struct packed {
        logic pair_odd;
        logic misalign;
        logic beyond;
        logic key_fault;
    } fault_flags_t;

    typedef struct packed {
        err_cause_e  cause;
        err_action_e action;
    } screen_result_t;

    function automatic logic [3:0] size_bytes(opnd_size_e sz);
        case (sz)
            SZ_HALF:   size_bytes = 4'd2;
            SZ_FULL:   size_bytes = 4'd4;
            SZ_DOUBLE: size_bytes = 4'd8;
            default:   size_bytes = 4'd1;
        endcase
    endfunction

    function automatic logic [2:0] align_mask(opnd_size_e sz);
        case (sz)
            SZ_HALF:   align_mask = 3'b001;
            SZ_FULL:   align_mask = 3'b011;
            SZ_DOUBLE: align_mask = 3'b111;
            default:   align_mask = 3'b000;
        endcase
    endfunction

    // Fixed priority: register pair, alignment, range, protection.
    function automatic screen_result_t resolve(fault_flags_t f, logic stm);
        screen_result_t r;
        if (f.pair_odd) begin
            r.cause  = CAUSE_REGPAIR;
            r.action = ACT_SUPPRESS;
        end else if (f.misalign) begin
            r.cause  = CAUSE_ALIGN;
            r.action = ACT_SUPPRESS;
        end else if (f.beyond) begin
            r.cause  = CAUSE_RANGE;
            r.action = ACT_TERMINATE;
        end else if (f.key_fault) begin
            r.cause  = CAUSE_PROTECT;
            r.action = stm ? ACT_TERMINATE : ACT_SUPPRESS;
        end else begin
            r.cause  = CAUSE_NONE;
            r.action = ACT_NONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/opnd_align_chk.sv
module opnd_align_chk
    import opnd_screen_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  opnd_size_e        size,
    input  logic              pair_op,
    input  logic [REG_W-1:0]  reg_num,
    output logic              misalign,
    output logic              pair_odd
);
    localparam logic [REG_W-1:0] ODD_BIT = {{(REG_W-1){1'b0}}, 1'b1};

    logic [2:0] low_bits;

    always_comb begin
        low_bits = addr[2:0] & align_mask(size);
        misalign = (low_bits != 3'b000);
        pair_odd = pair_op && ((reg_num & ODD_BIT) != '0);
    end

    always_comb begin
        if (size == SZ_BYTE) begin
            assert_byte_aligned_R1: assert (!misalign);
        end
    end
endmodule

// File: rtl/opnd_range_chk.sv
module opnd_range_chk
    import opnd_screen_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  opnd_size_e        size,
    input  logic [ADDR_W:0]   mem_bytes,
    output logic              beyond
);
    localparam int SPAN_W = ADDR_W + 1;

    logic [ADDR_W:0] last_byte;

    always_comb begin
        last_byte = {1'b0, addr} + SPAN_W'(size_bytes(size)) - SPAN_W'(1);
        beyond    = (last_byte >= mem_bytes);
    end

    always_comb begin
        if (mem_bytes == '0) begin
            assert_empty_mem_R5: assert (beyond);
        end
    end
endmodule

// File: rtl/opnd_key_chk.sv
module opnd_key_chk #(
    parameter int KEY_W = 4
) (
    input  logic             prot_en,
    input  logic [KEY_W-1:0] stor_key,
    input  logic [KEY_W-1:0] prot_key,
    output logic             key_fault
);
    logic master;

    always_comb begin
        master    = (prot_key == '0);
        key_fault = prot_en && !master && (prot_key != stor_key);
    end

    always_comb begin
        if (!prot_en) begin
            assert_prot_off_R7: assert (!key_fault);
        end
    end
endmodule

// File: rtl/opnd_addr_screen.sv
module opnd_addr_screen
    import opnd_screen_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 4,
    parameter int KEY_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [1:0]        opnd_size,
    input  logic              pair_op,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [ADDR_W:0]   mem_bytes,
    input  logic [KEY_W-1:0]  stor_key,
    input  logic [KEY_W-1:0]  prot_key,
    input  logic              prot_en,
    input  logic              is_stm,
    output logic              err_valid,
    output logic              err_req,
    output logic [2:0]        err_cause,
    output logic [1:0]        err_action
);
    opnd_size_e     size_sel;
    fault_flags_t   flags;
    screen_result_t res_d;
    screen_result_t res_q;
    logic           valid_q;

    assign size_sel = opnd_size_e'(opnd_size);

    opnd_align_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_align (
        .addr     (eff_addr),
        .size     (size_sel),
        .pair_op  (pair_op),
        .reg_num  (reg_num),
        .misalign (flags.misalign),
        .pair_odd (flags.pair_odd)
    );

    opnd_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .addr      (eff_addr),
        .size      (size_sel),
        .mem_bytes (mem_bytes),
        .beyond    (flags.beyond)
    );

    opnd_key_chk #(.KEY_W(KEY_W)) u_key (
        .prot_en   (prot_en),
        .stor_key  (stor_key),
        .prot_key  (prot_key),
        .key_fault (flags.key_fault)
    );

    always_comb begin
        res_d = resolve(flags, is_stm);
        if (!chk_valid) begin
            res_d.cause  = CAUSE_NONE;
            res_d.action = ACT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= 1'b0;
            res_q.cause  <= CAUSE_NONE;
            res_q.action <= ACT_NONE;
        end else begin
            valid_q <= chk_valid;
            res_q   <= res_d;
        end
    end

    assign err_valid  = valid_q;
    assign err_cause  = res_q.cause;
    assign err_action = res_q.action;
    assign err_req    = valid_q && (res_q.cause != CAUSE_NONE);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> err_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !err_req |-> (err_cause == 3'd0 && err_action == 2'd0));

    assert_pair_first_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && pair_op && reg_num[0]) |=>
        (err_req && err_cause == 3'd1 && err_action == 2'd1));

    assert_range_term_R5: assert property (@(posedge clk) disable iff (rst)
        (err_cause == 3'd3) |-> (err_action == 2'd2));

    assert_master_key_R8: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && prot_key == '0) |=> (err_cause != 3'd4));

    assert_stm_term_R6: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && is_stm) |=> (err_cause != 3'd4 || err_action == 2'd2));
endmodule

// File: tb/opnd_addr_screen_bench.sv
module opnd_addr_screen_bench;
    localparam int ADDR_W = 24;
    localparam int REG_W  = 4;
    localparam int KEY_W  = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              chk_valid;
    logic [ADDR_W-1:0] eff_addr;
    logic [1:0]        opnd_size;
    logic              pair_op;
    logic [REG_W-1:0]  reg_num;
    logic [ADDR_W:0]   mem_bytes;
    logic [KEY_W-1:0]  stor_key;
    logic [KEY_W-1:0]  prot_key;
    logic              prot_en;
    logic              is_stm;
    logic              err_valid;
    logic              err_req;
    logic [2:0]        err_cause;
    logic [1:0]        err_action;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    opnd_addr_screen #(.ADDR_W(ADDR_W), .REG_W(REG_W), .KEY_W(KEY_W)) u_opnd_addr_screen (
        .clk(clk), .rst(rst), .chk_valid(chk_valid), .eff_addr(eff_addr),
        .opnd_size(opnd_size), .pair_op(pair_op), .reg_num(reg_num),
        .mem_bytes(mem_bytes), .stor_key(stor_key), .prot_key(prot_key),
        .prot_en(prot_en), .is_stm(is_stm), .err_valid(err_valid),
        .err_req(err_req), .err_cause(err_cause), .err_action(err_action)
    );

    function automatic int nbytes(logic [1:0] sz);
        case (sz)
            2'd0: return 2;
            2'd1: return 4;
            2'd2: return 8;
            default: return 1;
        endcase
    endfunction

    // Expected {cause, action} from the requirements.
    function automatic logic [4:0] model();
        logic pr, al, rg, pk;
        longint last;
        pr = pair_op && reg_num[0];
        al = (opnd_size == 2'd0 && eff_addr[0]) ||
             (opnd_size == 2'd1 && eff_addr[1:0] != 2'b00) ||
             (opnd_size == 2'd2 && eff_addr[2:0] != 3'b000);
        last = longint'(eff_addr) + nbytes(opnd_size) - 1;
        rg = last >= longint'(mem_bytes);
        pk = prot_en && prot_key != 0 && prot_key != stor_key;
        if (pr) return {3'd1, 2'd1};
        if (al) return {3'd2, 2'd1};
        if (rg) return {3'd3, 2'd2};
        if (pk) return {3'd4, is_stm ? 2'd2 : 2'd1};
        return 5'd0;
    endfunction

    function automatic string tag_of(logic [2:0] c, logic [1:0] sz);
        case (c)
            3'd1: return "R4";
            3'd2: return (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R2" : "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [4:0] exp);
        logic [5:0] act, expv;
        act  = {err_req, err_cause, err_action};
        expv = {(exp[4:2] != 3'd0), exp};
        checks++;
        if (!err_valid || act !== expv) begin
            errors++;
            $display("FAIL %s: valid=%0b req/cause/action=%b expected valid=1 %b",
                     tag, err_valid, act, expv);
        end
    endtask

    task automatic apply(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                         input logic pr, input logic [REG_W-1:0] rn,
                         input logic [ADDR_W:0] mb, input logic [KEY_W-1:0] sk,
                         input logic [KEY_W-1:0] pk, input logic pe, input logic st,
                         input string tag);
        logic [4:0] exp;
        chk_valid = 1; eff_addr = a; opnd_size = sz; pair_op = pr; reg_num = rn;
        mem_bytes = mb; stor_key = sk; prot_key = pk; prot_en = pe; is_stm = st;
        exp = model();
        @(negedge clk);
        check(tag.len() == 0 ? tag_of(exp[4:2], sz) : tag, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        process::self().srandom(32'd1234);
        rst = 1; chk_valid = 0; eff_addr = '0; opnd_size = 0; pair_op = 0;
        reg_num = 0; mem_bytes = 25'h10000; stor_key = 0; prot_key = 0;
        prot_en = 0; is_stm = 0;
        repeat (3) @(negedge clk);
        checks++;
        if ({err_valid, err_req, err_cause, err_action} !== 7'd0) begin
            errors++;
            $display("FAIL R10 reset: got %b expected 0", {err_valid, err_req, err_cause, err_action});
        end
        rst = 0;
        @(negedge clk);
        checks++;
        if ({err_valid, err_req, err_cause, err_action} !== 7'd0) begin
            errors++;
            $display("FAIL R10 idle: got %b expected 0", {err_valid, err_req, err_cause, err_action});
        end
        // Directed corner cases
        apply(24'h101, 2'd0, 0, 0, 25'h10000, 0, 0, 0, 0, "R1");
        apply(24'h101, 2'd3, 0, 0, 25'h10000, 0, 0, 0, 0, "R1");
        apply(24'h102, 2'd1, 0, 0, 25'h10000, 0, 0, 0, 0, "R2");
        apply(24'h104, 2'd1, 0, 0, 25'h10000, 0, 0, 0, 0, "R2");
        apply(24'h104, 2'd2, 0, 0, 25'h10000, 0, 0, 0, 0, "R3");
        apply(24'h108, 2'd2, 0, 0, 25'h10000, 0, 0, 0, 0, "R3");
        apply(24'h108, 2'd2, 1, 5, 25'h10000, 0, 0, 0, 0, "R4");
        apply(24'h108, 2'd2, 1, 6, 25'h10000, 0, 0, 0, 0, "R4");
        apply(24'hFFF8, 2'd2, 0, 0, 25'h10000, 0, 0, 0, 0, "R5");
        apply(24'hFFFC, 2'd2, 0, 0, 25'h10000, 0, 0, 0, 0, "R5");
        apply(24'h10000, 2'd3, 0, 0, 25'h10000, 0, 0, 0, 0, "R5");
        apply(24'h200, 2'd1, 0, 0, 25'h10000, 3, 5, 1, 0, "R6");
        apply(24'h200, 2'd1, 0, 0, 25'h10000, 3, 5, 1, 1, "R6");
        apply(24'h200, 2'd1, 0, 0, 25'h10000, 3, 3, 1, 1, "R6");
        apply(24'h200, 2'd1, 0, 0, 25'h10000, 3, 5, 0, 1, "R7");
        apply(24'h200, 2'd1, 0, 0, 25'h10000, 9, 0, 1, 0, "R8");
        apply(24'hFFFF, 2'd1, 1, 3, 25'h10000, 3, 5, 1, 1, "R9");
        apply(24'hFFFF, 2'd1, 0, 3, 25'h10000, 3, 5, 1, 1, "R9");
        apply(24'hFFFC, 2'd2, 0, 0, 25'h10000, 3, 5, 1, 0, "R9");
        apply(24'h3000, 2'd2, 0, 0, 25'h2000, 3, 5, 1, 0, "R9");
        // Valid dropped: outputs go quiet one cycle later
        chk_valid = 0; eff_addr = 24'h1;
        @(negedge clk);
        checks++;
        if ({err_valid, err_req, err_cause, err_action} !== 7'd0) begin
            errors++;
            $display("FAIL R10 valid low: got %b expected 0", {err_valid, err_req, err_cause, err_action});
        end
        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W:0] mb;
            mb = 25'h8000 + 25'($urandom_range(0, 32'h8000));
            apply(24'($urandom_range(0, int'(mb) + 16)), 2'($urandom),
                  ($urandom_range(0, 3) == 0), 4'($urandom), mb,
                  4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)),
                  1'($urandom), 1'($urandom), "");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule